// File: doc/BRIEF.md
# Two-Wide Fetch Next-PC Selector

This block picks the address of the next fetch for a front end that reads two instructions per cycle from an aligned fetch block. A slot is the older or younger of the two fetched instructions. For each slot, tables outside the block supply three things: a target-buffer tag hit, a predicted-taken direction and a predicted target. The block ranks the two predictions in program order. It cancels the younger slot when the older one is predicted taken, and it cuts the fetch to a single instruction when the fetch PC is the last word of its cache block.

The block also holds the fetch PC register. At reset the register takes a fixed vector. It holds its value while the stall input is high. A redirect from branch resolution overrides every prediction and loads the corrected address, including during a stall. The block's outputs are the current PC, the next PC, a valid bit for the younger slot and a one-hot flag that names the taken slot.

Top module: `fetch_npc_sel`

## Requirements
- R1: After reset, `pc_o` equals the parameter `RESET_VEC` (default 0x0000_1000).
- R2: When no slot qualifies as predicted taken and `blk_last_i` is 0, `next_pc_o` = `pc_o` + 8, `slot1_valid_o` = 1 and `taken_slot_o` = 2'b00.
- R3: `taken_slot_o` is one-hot or zero. Bit 0 marks the older slot and bit 1 marks the younger slot. A taken slot's target becomes `next_pc_o`.
- R4: When the older slot is predicted taken, `slot1_valid_o` = 0 and the younger slot's prediction is not used.
- R5: When only the younger slot is predicted taken, `next_pc_o` = `s1_target_i` and `taken_slot_o` = 2'b10.
- R6: When both slots are predicted taken, the older slot wins: `next_pc_o` = `s0_target_i` and `taken_slot_o` = 2'b01.
- R7: A taken flag without its tag hit is ignored. That slot is treated as not taken.
- R8: When `blk_last_i` = 1, one instruction is delivered. `slot1_valid_o` = 0, the younger slot's inputs are ignored, and the not-taken next PC is `pc_o` + 4.
- R9: With no stall and no redirect, `pc_o` takes the value of `next_pc_o` at the next clock edge.
- R10: With `stall_i` = 1 and no redirect, `pc_o` holds its value.
- R11: `redirect_i` = 1 sets `next_pc_o` to `redirect_pc_i`, and `pc_o` takes that value at the next edge, even during a stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall_i | input | 1 | Hold the fetch PC |
| redirect_i | input | 1 | Resolution override |
| redirect_pc_i | input | PC_W | Corrected fetch address |
| s0_hit_i | input | 1 | Older slot target-buffer tag hit |
| s0_taken_i | input | 1 | Older slot predicted taken |
| s0_target_i | input | PC_W | Older slot predicted target |
| s1_hit_i | input | 1 | Younger slot target-buffer tag hit |
| s1_taken_i | input | 1 | Younger slot predicted taken |
| s1_target_i | input | PC_W | Younger slot predicted target |
| blk_last_i | input | 1 | Fetch PC is last word of its cache block |
| pc_o | output | PC_W | Current fetch PC |
| next_pc_o | output | PC_W | Address the PC loads next |
| slot1_valid_o | output | 1 | Younger slot delivered |
| taken_slot_o | output | 2 | One-hot taken slot (bit 0 older) |

## Verification
The bench checks the case where both slots are taken. A design with the priority reversed would jump to the younger target. It checks a taken flag without a tag hit, which a careless qualifier would follow as a jump. At a block end it sets a younger slot that is predicted taken: a wrong design would either take that phantom branch or step the PC by 8 and skip an instruction. It also drives a redirect during a stall, which a register that gives stall priority would lose.

// File: rtl/fetch_npc_pkg.sv
`timescale 1ns/1ps
package fetch_npc_pkg;
  localparam int NSLOT = 2;
  typedef enum logic [1:0] {
    SRC_SEQ_FULL,
    SRC_SEQ_HALF,
    SRC_PRED,
    SRC_REDIR
  } npc_src_e;
endpackage

// File: rtl/npc_slot_qual.sv
`timescale 1ns/1ps
module npc_slot_qual (
  input  logic hit_i,
  input  logic taken_i,
  input  logic in_block_i,
  output logic pred_taken_o
);
  // A slot steers fetch only with a tag hit, a taken guess, and being inside the block.
  always_comb begin
    pred_taken_o = hit_i & taken_i & in_block_i;
  end
endmodule

// File: rtl/npc_priority.sv
`timescale 1ns/1ps
module npc_priority #(
  parameter int N = 2
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] first_o,
  output logic [N-1:0] kill_o,
  output logic         any_o
);
  logic [N:0] seen;

  always_comb begin
    seen[0] = 1'b0;
    for (int i = 0; i < N; i++) begin
      first_o[i]  = req_i[i] & ~seen[i];
      kill_o[i]   = seen[i];
      seen[i+1]   = seen[i] | req_i[i];
    end
    any_o = seen[N];
  end
endmodule

// File: rtl/npc_pc_reg.sv
`timescale 1ns/1ps
module npc_pc_reg #(
  parameter int          PC_W      = 32,
  parameter logic [31:0] RESET_VEC = 32'h0000_1000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            stall_i,
  input  logic            redirect_i,
  input  logic [PC_W-1:0] redirect_pc_i,
  input  logic [PC_W-1:0] npc_i,
  output logic [PC_W-1:0] pc_o
);
  logic [1:0]      rst_sync_q;
  logic            rst_q;
  logic            pc_en;
  logic [PC_W-1:0] pc_d;
  logic [PC_W-1:0] pc_q;

  // reset asserts at once, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q = rst_sync_q[1];

  always_comb begin
    pc_en = redirect_i | ~stall_i;
    pc_d  = redirect_i ? redirect_pc_i : npc_i;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q)     pc_q <= RESET_VEC[PC_W-1:0];
    else if (pc_en) pc_q <= pc_d;
  end

  assign pc_o = pc_q;

  p_load_r9: assert property (@(posedge clk) disable iff (!rst_q)
    (!stall_i && !redirect_i) |=> (pc_q == $past(npc_i)));
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_q)
    (stall_i && !redirect_i) |=> $stable(pc_q));
  p_redirect_r11: assert property (@(posedge clk) disable iff (!rst_q)
    redirect_i |=> (pc_q == $past(redirect_pc_i)));
endmodule

// File: rtl/fetch_npc_sel.sv
`timescale 1ns/1ps
module fetch_npc_sel
  import fetch_npc_pkg::*;
#(
  parameter int          PC_W       = 32,
  parameter int          INST_BYTES = 4,
  parameter logic [31:0] RESET_VEC  = 32'h0000_1000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            stall_i,
  input  logic            redirect_i,
  input  logic [PC_W-1:0] redirect_pc_i,
  input  logic            s0_hit_i,
  input  logic            s0_taken_i,
  input  logic [PC_W-1:0] s0_target_i,
  input  logic            s1_hit_i,
  input  logic            s1_taken_i,
  input  logic [PC_W-1:0] s1_target_i,
  input  logic            blk_last_i,
  output logic [PC_W-1:0] pc_o,
  output logic [PC_W-1:0] next_pc_o,
  output logic            slot1_valid_o,
  output logic [1:0]      taken_slot_o
);
  localparam int FULL_STEP = NSLOT * INST_BYTES;
  localparam int HALF_STEP = INST_BYTES;

  logic [NSLOT-1:0]           hit_v, taken_v, in_blk_v, pred_v;
  logic [NSLOT-1:0][PC_W-1:0] tgt_v;
  logic [NSLOT-1:0]           first_v, kill_v;
  logic                       any_pred;
  logic [PC_W-1:0]            pc_cur, pred_tgt;
  npc_src_e                   src;

  always_comb begin
    hit_v   = {s1_hit_i, s0_hit_i};
    taken_v = {s1_taken_i, s0_taken_i};
    tgt_v[0] = s0_target_i;
    tgt_v[1] = s1_target_i;
  end

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    // only the older slot survives a block-end fetch
    if (g == 0) begin : g_old
      assign in_blk_v[g] = 1'b1;
    end else begin : g_young
      assign in_blk_v[g] = ~blk_last_i;
    end
    npc_slot_qual u_qual (
      .hit_i        (hit_v[g]),
      .taken_i      (taken_v[g]),
      .in_block_i   (in_blk_v[g]),
      .pred_taken_o (pred_v[g])
    );
  end

  npc_priority #(.N(NSLOT)) u_prio (
    .req_i   (pred_v),
    .first_o (first_v),
    .kill_o  (kill_v),
    .any_o   (any_pred)
  );

  always_comb begin
    pred_tgt = '0;
    for (int i = 0; i < NSLOT; i++) begin
      if (first_v[i]) pred_tgt = tgt_v[i];
    end
  end

  always_comb begin
    if (redirect_i)      src = SRC_REDIR;
    else if (any_pred)   src = SRC_PRED;
    else if (blk_last_i) src = SRC_SEQ_HALF;
    else                 src = SRC_SEQ_FULL;
  end

  always_comb begin
    unique case (src)
      SRC_REDIR:    next_pc_o = redirect_pc_i;
      SRC_PRED:     next_pc_o = pred_tgt;
      SRC_SEQ_HALF: next_pc_o = pc_cur + PC_W'(HALF_STEP);
      default:      next_pc_o = pc_cur + PC_W'(FULL_STEP);
    endcase
  end

  npc_pc_reg #(.PC_W(PC_W), .RESET_VEC(RESET_VEC)) u_pc (
    .clk           (clk),
    .rst_n         (rst_n),
    .stall_i       (stall_i),
    .redirect_i    (redirect_i),
    .redirect_pc_i (redirect_pc_i),
    .npc_i         (next_pc_o),
    .pc_o          (pc_cur)
  );

  always_comb begin
    pc_o          = pc_cur;
    slot1_valid_o = in_blk_v[1] & ~kill_v[1];
    taken_slot_o  = first_v;
  end

  p_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(taken_slot_o));
  p_cancel_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (s0_hit_i && s0_taken_i) |-> (!slot1_valid_o && taken_slot_o == 2'b01));
  p_nohit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!s0_hit_i && !s1_hit_i) |-> (taken_slot_o == 2'b00));
  p_blkend_r8: assert property (@(posedge clk) disable iff (!rst_n)
    blk_last_i |-> (!slot1_valid_o && !taken_slot_o[1]));
  p_seq_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!redirect_i && taken_slot_o == 2'b00 && !blk_last_i) |-> (next_pc_o == pc_o + PC_W'(FULL_STEP)));
endmodule

// File: tb/fetch_npc_sel_bench.sv
`timescale 1ns/1ps
module fetch_npc_sel_bench;
  localparam int          PC_W = 32;
  localparam logic [31:0] RV   = 32'h0000_1000;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            stall_i, redirect_i, s0_hit_i, s0_taken_i, s1_hit_i, s1_taken_i, blk_last_i;
  logic [PC_W-1:0] redirect_pc_i, s0_target_i, s1_target_i;
  logic [PC_W-1:0] pc_o, next_pc_o;
  logic            slot1_valid_o;
  logic [1:0]      taken_slot_o;

  int errors = 0;
  int checks = 0;

  typedef struct {
    logic [PC_W-1:0] npc;
    logic            s1v;
    logic [1:0]      ts;
    logic [PC_W-1:0] pc_after;
    string           tag;
  } exp_t;

  exp_t exp_q[$];
  event ev_sample;
  logic [PC_W-1:0] exp_pc;

  always #10 clk = ~clk;

  fetch_npc_sel #(.PC_W(PC_W), .RESET_VEC(RV)) u_fetch_npc_sel (
    .clk(clk), .rst_n(rst_n), .stall_i(stall_i), .redirect_i(redirect_i),
    .redirect_pc_i(redirect_pc_i), .s0_hit_i(s0_hit_i), .s0_taken_i(s0_taken_i),
    .s0_target_i(s0_target_i), .s1_hit_i(s1_hit_i), .s1_taken_i(s1_taken_i),
    .s1_target_i(s1_target_i), .blk_last_i(blk_last_i), .pc_o(pc_o),
    .next_pc_o(next_pc_o), .slot1_valid_o(slot1_valid_o), .taken_slot_o(taken_slot_o)
  );

  task automatic chk(input string tag, input string what, input logic [PC_W-1:0] act, input logic [PC_W-1:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  task automatic step(input string tag, input logic st, input logic rd, input logic [PC_W-1:0] rpc,
                      input logic h0, input logic t0, input logic [PC_W-1:0] g0,
                      input logic h1, input logic t1, input logic [PC_W-1:0] g1, input logic last);
    exp_t e;
    logic p0, p1;
    @(negedge clk);
    stall_i = st; redirect_i = rd; redirect_pc_i = rpc;
    s0_hit_i = h0; s0_taken_i = t0; s0_target_i = g0;
    s1_hit_i = h1; s1_taken_i = t1; s1_target_i = g1; blk_last_i = last;
    p0 = h0 & t0;
    p1 = h1 & t1 & ~last & ~p0;
    if (rd)        e.npc = rpc;
    else if (p0)   e.npc = g0;
    else if (p1)   e.npc = g1;
    else if (last) e.npc = exp_pc + 32'd4;
    else           e.npc = exp_pc + 32'd8;
    e.s1v = ~last & ~p0;
    e.ts  = {p1, p0};
    e.pc_after = (rd || !st) ? e.npc : exp_pc;
    e.tag = tag;
    exp_q.push_back(e);
    exp_pc = e.pc_after;
    #5 -> ev_sample;
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(ev_sample);
      e = exp_q.pop_front();
      chk(e.tag, "next_pc", next_pc_o, e.npc);
      chk(e.tag, "slot1_valid", {31'd0, slot1_valid_o}, {31'd0, e.s1v});
      chk(e.tag, "taken_slot", {30'd0, taken_slot_o}, {30'd0, e.ts});
      @(posedge clk);
      #2;
      chk(e.tag, "pc_after", pc_o, e.pc_after);
    end
  end

  initial begin : watchdog
    #(20 * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : driver
    rst_n = 1'b0; stall_i = 1'b1; redirect_i = 1'b0; redirect_pc_i = '0;
    s0_hit_i = 0; s0_taken_i = 0; s0_target_i = '0;
    s1_hit_i = 0; s1_taken_i = 0; s1_target_i = '0; blk_last_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "reset pc", pc_o, RV);
    exp_pc = RV;
    // R2 sequential two-wide steps
    step("R2", 0, 0, '0, 0, 0, '0, 0, 0, '0, 0);
    step("R9", 0, 0, '0, 0, 0, 32'h5000, 0, 0, 32'h6000, 0);
    // R3 / R4 older slot taken cancels younger
    step("R4", 0, 0, '0, 1, 1, 32'h2000, 0, 0, '0, 0);
    // R5 younger only
    step("R5", 0, 0, '0, 0, 0, 32'h7700, 1, 1, 32'h3000, 0);
    // R6 both taken, older wins
    step("R6", 0, 0, '0, 1, 1, 32'h4000, 1, 1, 32'h4800, 0);
    // R7 taken without hit ignored, on both slots
    step("R7", 0, 0, '0, 0, 1, 32'h9000, 0, 1, 32'h9100, 0);
    step("R7", 0, 0, '0, 1, 0, 32'h9000, 0, 1, 32'h9100, 0);
    // R8 block end: younger prediction ignored, +4
    step("R8", 0, 0, '0, 0, 0, '0, 1, 1, 32'hA000, 1);
    step("R8", 0, 0, '0, 1, 1, 32'hB000, 1, 1, 32'hA000, 1);
    // R10 stall holds with a taken prediction present
    step("R10", 1, 0, '0, 1, 1, 32'hC000, 0, 0, '0, 0);
    step("R10", 1, 0, '0, 0, 0, '0, 0, 0, '0, 1);
    // R11 redirect overrides prediction and stall
    step("R11", 0, 1, 32'h0000_8000, 1, 1, 32'hD000, 1, 1, 32'hE000, 0);
    step("R11", 1, 1, 32'h0000_8804, 0, 0, '0, 0, 0, '0, 0);
    step("R3", 0, 0, '0, 0, 0, '0, 1, 1, 32'h0000_F000, 0);
    step("R2", 0, 0, '0, 0, 0, '0, 0, 0, '0, 0);
    @(negedge clk);
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule